// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit decides where a 32-bit RISC core fetches next. Each cycle it takes the address of the instruction being resolved, the instruction word and the two operand values the register file has already read (the first from the register named in bits 25:21, the second from bits 20:16). One clock edge later it presents the next fetch address, a write request for the fixed link register with the value to store, an exception request with a cause code, and a hint that tells the return-address predictor what kind of register jump was taken.

Six compare-and-branch opcodes, a long unconditional relative branch, relative and register calls, a register jump with return variants and a software-interrupt opcode are handled. Every other opcode steps to the next word. Looking up an exception vector and flushing the pipeline stay with the core; the unit only raises the request and names the cause.

Top module: `bru_next_pc`

## Requirements
- R1: For any opcode (bits 31:26) outside 17..21, 23, 43, 48, 54, 56 and 62 the next PC is the current PC plus 4, wrapping modulo 2^32, with no link write and no exception.
- R2: Opcodes 17 (equal), 23 (not equal), 18 (signed greater), 19 (signed greater or equal), 21 (unsigned greater) and 20 (unsigned greater or equal) compare the first operand against the second; signed ones use two's complement, unsigned ones magnitude; when the condition fails the next PC is PC plus 4.
- R3: A taken conditional branch goes to PC plus the sign-extended bits 15:0 multiplied by 4.
- R4: Opcodes 56 (branch) and 62 (call) go to PC plus the sign-extended bits 25:0 multiplied by 4.
- R5: Opcodes 54 (register call) and 62 raise the link write for register 29 with data PC plus 4; no other opcode raises it.
- R6: Opcodes 48 and 54 go to the first operand; for opcode 48 the return hint is 1, 2 or 3 when bits 25:21 are 29, 30 or 31 and 0 otherwise; the hint is 0 for every other opcode.
- R7: Opcode 43 raises the exception request with the next PC equal to the current PC and no link write; bits 25:0 equal to 2 give cause 2 (breakpoint), equal to 7 give cause 7 (system call), any other value gives cause 4 (illegal); the cause is 0 without a request.
- R8: All outputs are registered one cycle after their inputs; while the synchronous active-low reset is asserted the next PC, link data, cause and hint are 0 and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| curPc | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word |
| regA | input | 32 | Value of the register named by bits 25:21 |
| regB | input | 32 | Value of the register named by bits 20:16 |
| nextPc | output | 32 | Next fetch address |
| linkWe | output | 1 | Write request for link register 29 |
| linkData | output | 32 | Return address to write |
| excReq | output | 1 | Exception request |
| excCause | output | 3 | Exception cause code |
| retKind | output | 2 | Register jump hint: 0 plain, 1 return, 2 exception return, 3 breakpoint return |

## Verification
A wrong decode or compare shows up as a wrong nextPc on the very first edge after the instruction is presented, since there is only one register stage and no state carries between instructions. The sign and magnitude compares are exercised with operands whose signed and unsigned orderings disagree, so swapping the two compare kinds changes nextPc. A stray link or exception strobe is visible on the same edge, and a bad reset value is seen at the first sample taken while reset is held.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int XLEN = 32;
  localparam int OPC_W = 6;
  localparam int CAUSE_W = 3;

  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd17;
  localparam logic [OPC_W-1:0] OPC_BGTS  = 6'd18;
  localparam logic [OPC_W-1:0] OPC_BGES  = 6'd19;
  localparam logic [OPC_W-1:0] OPC_BGEU  = 6'd20;
  localparam logic [OPC_W-1:0] OPC_BGTU  = 6'd21;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'd23;
  localparam logic [OPC_W-1:0] OPC_TRAP  = 6'd43;
  localparam logic [OPC_W-1:0] OPC_JREG  = 6'd48;
  localparam logic [OPC_W-1:0] OPC_CREG  = 6'd54;
  localparam logic [OPC_W-1:0] OPC_JREL  = 6'd56;
  localparam logic [OPC_W-1:0] OPC_CREL  = 6'd62;

  localparam logic [CAUSE_W-1:0] CAUSE_BRK = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_ILL = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_SYS = 3'd7;

  typedef enum logic [2:0] {
    CMP_NONE, CMP_EQ, CMP_NE, CMP_GTS, CMP_GES, CMP_GTU, CMP_GEU
  } cmpSel_e;

  typedef enum logic [2:0] {
    TGT_SEQ, TGT_NEAR, TGT_FAR, TGT_REG, TGT_HOLD
  } tgtSel_e;

  typedef struct packed {
    cmpSel_e              cmpSel;
    tgtSel_e              tgtSel;
    logic                 linkEn;
    logic                 excEn;
    logic [CAUSE_W-1:0]   cause;
    logic [1:0]           retKind;
  } ctrl_t;
endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int LINK_IDX = 29
) (
  input  logic [INSN_W-1:0] instr,
  output ctrl_t             ctrl
);
  localparam int FIELD_W = INSN_W - OPC_W;
  localparam int IDX_W = 5;

  logic [OPC_W-1:0]   opcode;
  logic [FIELD_W-1:0] trapField;
  logic [IDX_W-1:0]   srcIdx;

  assign opcode    = instr[INSN_W-1 -: OPC_W];
  assign trapField = instr[FIELD_W-1:0];
  assign srcIdx    = instr[FIELD_W-1 -: IDX_W];

  always_comb begin
    ctrl = '{cmpSel: CMP_NONE, tgtSel: TGT_SEQ, linkEn: 1'b0, excEn: 1'b0,
             cause: '0, retKind: 2'd0};
    case (opcode)
      OPC_BEQ:  begin ctrl.cmpSel = CMP_EQ;  ctrl.tgtSel = TGT_NEAR; end
      OPC_BNE:  begin ctrl.cmpSel = CMP_NE;  ctrl.tgtSel = TGT_NEAR; end
      OPC_BGTS: begin ctrl.cmpSel = CMP_GTS; ctrl.tgtSel = TGT_NEAR; end
      OPC_BGES: begin ctrl.cmpSel = CMP_GES; ctrl.tgtSel = TGT_NEAR; end
      OPC_BGTU: begin ctrl.cmpSel = CMP_GTU; ctrl.tgtSel = TGT_NEAR; end
      OPC_BGEU: begin ctrl.cmpSel = CMP_GEU; ctrl.tgtSel = TGT_NEAR; end
      OPC_JREL: ctrl.tgtSel = TGT_FAR;
      OPC_CREL: begin ctrl.tgtSel = TGT_FAR; ctrl.linkEn = 1'b1; end
      OPC_CREG: begin ctrl.tgtSel = TGT_REG; ctrl.linkEn = 1'b1; end
      OPC_JREG: begin
        ctrl.tgtSel = TGT_REG;
        if (srcIdx == IDX_W'(LINK_IDX))          ctrl.retKind = 2'd1;
        else if (srcIdx == IDX_W'(LINK_IDX + 1)) ctrl.retKind = 2'd2;
        else if (srcIdx == IDX_W'(LINK_IDX + 2)) ctrl.retKind = 2'd3;
      end
      OPC_TRAP: begin
        ctrl.tgtSel = TGT_HOLD;
        ctrl.excEn  = 1'b1;
        if (trapField == FIELD_W'(CAUSE_BRK))      ctrl.cause = CAUSE_BRK;
        else if (trapField == FIELD_W'(CAUSE_SYS)) ctrl.cause = CAUSE_SYS;
        else                                       ctrl.cause = CAUSE_ILL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bru_dpath.sv
module bru_dpath
  import bru_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int NEAR_W = 16,
  parameter int FAR_W = 26,
  parameter int WORD_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_W-1:0]     curPc,
  input  logic [FAR_W-1:0]    offField,
  input  logic [PC_W-1:0]     regA,
  input  logic [PC_W-1:0]     regB,
  input  ctrl_t               ctrl,
  output logic [PC_W-1:0]     nextPc,
  output logic                linkWe,
  output logic [PC_W-1:0]     linkData,
  output logic                excReq,
  output logic [CAUSE_W-1:0]  excCause,
  output logic [1:0]          retKind
);
  localparam int STEP = 1 << WORD_SHIFT;

  logic signed [PC_W-1:0] nearOff;
  logic signed [PC_W-1:0] farOff;
  logic [PC_W-1:0] seqPc, nearPc, farPc, nextComb;
  logic isEq, isGts, isGtu, taken;

  assign nearOff = PC_W'($signed(offField[NEAR_W-1:0]));
  assign farOff  = PC_W'($signed(offField));
  assign seqPc   = curPc + PC_W'(STEP);
  assign nearPc  = curPc + PC_W'(nearOff << WORD_SHIFT);
  assign farPc   = curPc + PC_W'(farOff << WORD_SHIFT);

  assign isEq  = (regA == regB);
  assign isGts = ($signed(regA) > $signed(regB));
  assign isGtu = (regA > regB);

  always_comb begin
    case (ctrl.cmpSel)
      CMP_EQ:  taken = isEq;
      CMP_NE:  taken = !isEq;
      CMP_GTS: taken = isGts;
      CMP_GES: taken = isGts || isEq;
      CMP_GTU: taken = isGtu;
      CMP_GEU: taken = isGtu || isEq;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    case (ctrl.tgtSel)
      TGT_NEAR: nextComb = taken ? nearPc : seqPc;
      TGT_FAR:  nextComb = farPc;
      TGT_REG:  nextComb = regA;
      TGT_HOLD: nextComb = curPc;
      default:  nextComb = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc   <= '0;
      linkWe   <= 1'b0;
      linkData <= '0;
      excReq   <= 1'b0;
      excCause <= '0;
      retKind  <= 2'd0;
    end else begin
      nextPc   <= nextComb;
      linkWe   <= ctrl.linkEn;
      linkData <= ctrl.linkEn ? seqPc : '0;
      excReq   <= ctrl.excEn;
      excCause <= ctrl.cause;
      retKind  <= ctrl.retKind;
    end
  end
endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
  import bru_pkg::*;
#(
  parameter int NEAR_W = 16,
  parameter int FAR_W = 26
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [XLEN-1:0]     curPc,
  input  logic [XLEN-1:0]     instr,
  input  logic [XLEN-1:0]     regA,
  input  logic [XLEN-1:0]     regB,
  output logic [XLEN-1:0]     nextPc,
  output logic                linkWe,
  output logic [XLEN-1:0]     linkData,
  output logic                excReq,
  output logic [CAUSE_W-1:0]  excCause,
  output logic [1:0]          retKind
);
  ctrl_t ctrl;

  bru_ctrl #(.INSN_W(XLEN), .LINK_IDX(29)) uCtrl (
    .instr (instr),
    .ctrl  (ctrl)
  );

  bru_dpath #(.PC_W(XLEN), .NEAR_W(NEAR_W), .FAR_W(FAR_W), .WORD_SHIFT(2)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .curPc    (curPc),
    .offField (instr[FAR_W-1:0]),
    .regA     (regA),
    .regB     (regB),
    .ctrl     (ctrl),
    .nextPc   (nextPc),
    .linkWe   (linkWe),
    .linkData (linkData),
    .excReq   (excReq),
    .excCause (excCause),
    .retKind  (retKind)
  );
endmodule

// File: rtl/bru_chk.sv
module bru_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] curPc,
  input logic [5:0]  opcode,
  input logic [4:0]  srcIdx,
  input logic [31:0] regA,
  input logic [31:0] nextPc,
  input logic        linkWe,
  input logic [31:0] linkData,
  input logic        excReq,
  input logic [2:0]  excCause,
  input logic [1:0]  retKind
);
  logic primed;
  always_ff @(posedge clk) primed <= rstN;

  function automatic logic flowOp(input logic [5:0] op);
    return (op >= 6'd17 && op <= 6'd21) || op == 6'd23 || op == 6'd43 ||
           op == 6'd48 || op == 6'd54 || op == 6'd56 || op == 6'd62;
  endfunction

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    primed && !flowOp($past(opcode)) |-> nextPc == $past(curPc) + 32'd4 && !linkWe && !excReq); // R1
  AST_LINK_DATA: assert property (@(posedge clk) disable iff (!rstN)
    primed && linkWe |-> linkData == $past(curPc) + 32'd4); // R5
  AST_LINK_SRC: assert property (@(posedge clk) disable iff (!rstN)
    primed && linkWe |-> ($past(opcode) == 6'd54 || $past(opcode) == 6'd62)); // R5
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    primed && excReq |-> !linkWe && nextPc == $past(curPc)); // R7
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excCause == 3'd2 || excCause == 3'd4 || excCause == 3'd7)); // R7
  AST_RET_HINT: assert property (@(posedge clk) disable iff (!rstN)
    primed && retKind != 2'd0 |-> nextPc == $past(regA) && $past(srcIdx) >= 5'd29); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> nextPc == 32'd0 && !linkWe && !excReq && retKind == 2'd0); // R8
endmodule

bind bru_next_pc bru_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .curPc    (curPc),
  .opcode   (instr[31:26]),
  .srcIdx   (instr[25:21]),
  .regA     (regA),
  .nextPc   (nextPc),
  .linkWe   (linkWe),
  .linkData (linkData),
  .excReq   (excReq),
  .excCause (excCause),
  .retKind  (retKind)
);

// File: tb/bru_next_pc_test.sv
module bru_next_pc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] curPc = '0, instr = '0, regA = '0, regB = '0;
  logic [31:0] nextPc, linkData;
  logic linkWe, excReq;
  logic [2:0] excCause;
  logic [1:0] retKind;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bru_next_pc uut (
    .clk(clk), .rstN(rstN), .curPc(curPc), .instr(instr), .regA(regA), .regB(regB),
    .nextPc(nextPc), .linkWe(linkWe), .linkData(linkData), .excReq(excReq),
    .excCause(excCause), .retKind(retKind)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] pc;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expPc;
    logic        expWe;
    logic        expExc;
    logic [2:0]  expCause;
    logic [1:0]  expRet;
  } vec_t;

  function automatic logic [31:0] encCmp(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction
  function automatic logic [31:0] encFar(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction
  function automatic logic [31:0] encReg(input logic [5:0] op, input logic [4:0] ra);
    return {op, ra, 21'd0};
  endfunction

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 32'h1000, encCmp(6'd17, 16'h0004), 32'd5, 32'd5, 32'h1010, 1'b0, 1'b0, 3'd0, 2'd0},          // R3 R2 eq taken
    '{4'd2, 32'h1000, encCmp(6'd17, 16'h0004), 32'd5, 32'd6, 32'h1004, 1'b0, 1'b0, 3'd0, 2'd0},          // R2 eq not taken
    '{4'd2, 32'h2000, encCmp(6'd18, 16'h0004), 32'hFFFFFFFF, 32'd1, 32'h2004, 1'b0, 1'b0, 3'd0, 2'd0},   // R2 signed -1 > 1 fails
    '{4'd3, 32'h2000, encCmp(6'd21, 16'hFFFC), 32'hFFFFFFFF, 32'd1, 32'h1FF0, 1'b0, 1'b0, 3'd0, 2'd0},   // R3 unsigned taken, back
    '{4'd2, 32'h3000, encCmp(6'd19, 16'h0010), 32'd7, 32'd7, 32'h3040, 1'b0, 1'b0, 3'd0, 2'd0},          // R2 signed ge on equal
    '{4'd2, 32'h3000, encCmp(6'd20, 16'h0010), 32'd1, 32'hFFFFFFFF, 32'h3004, 1'b0, 1'b0, 3'd0, 2'd0},   // R2 unsigned ge fails
    '{4'd3, 32'h40000, encCmp(6'd23, 16'h8000), 32'd1, 32'd2, 32'h20000, 1'b0, 1'b0, 3'd0, 2'd0},        // R3 most negative
    '{4'd2, 32'h600, encCmp(6'd18, 16'h0002), 32'd1, 32'hFFFFFFFF, 32'h608, 1'b0, 1'b0, 3'd0, 2'd0},     // R2 signed 1 > -1
    '{4'd2, 32'h700, encCmp(6'd19, 16'h0002), 32'h80000000, 32'd0, 32'h704, 1'b0, 1'b0, 3'd0, 2'd0},     // R2 min < 0
    '{4'd4, 32'h5000, encFar(6'd56, 26'h0000010), 32'd0, 32'd0, 32'h5040, 1'b0, 1'b0, 3'd0, 2'd0},       // R4 forward
    '{4'd4, 32'h5000, encFar(6'd56, 26'h3FFFFFF), 32'd0, 32'd0, 32'h4FFC, 1'b0, 1'b0, 3'd0, 2'd0},       // R4 back one word
    '{4'd5, 32'h09000000, encFar(6'd62, 26'h2000000), 32'd0, 32'd0, 32'h01000000, 1'b1, 1'b0, 3'd0, 2'd0}, // R5 R4 far call
    '{4'd5, 32'h100, encReg(6'd54, 5'd4), 32'h12345678, 32'd0, 32'h12345678, 1'b1, 1'b0, 3'd0, 2'd0},    // R5 register call
    '{4'd6, 32'h100, encReg(6'd48, 5'd3), 32'hABCD0000, 32'd0, 32'hABCD0000, 1'b0, 1'b0, 3'd0, 2'd0},    // R6 plain jump
    '{4'd6, 32'h100, encReg(6'd48, 5'd29), 32'h200, 32'd0, 32'h200, 1'b0, 1'b0, 3'd0, 2'd1},             // R6 return
    '{4'd6, 32'h100, encReg(6'd48, 5'd30), 32'h300, 32'd0, 32'h300, 1'b0, 1'b0, 3'd0, 2'd2},             // R6 exception return
    '{4'd6, 32'h100, encReg(6'd48, 5'd31), 32'h400, 32'd0, 32'h400, 1'b0, 1'b0, 3'd0, 2'd3},             // R6 breakpoint return
    '{4'd7, 32'h800, encFar(6'd43, 26'd2), 32'd0, 32'd0, 32'h800, 1'b0, 1'b1, 3'd2, 2'd0},               // R7 breakpoint
    '{4'd7, 32'h800, encFar(6'd43, 26'd7), 32'd0, 32'd0, 32'h800, 1'b0, 1'b1, 3'd7, 2'd0},               // R7 system call
    '{4'd7, 32'h804, encFar(6'd43, 26'd5), 32'd0, 32'd0, 32'h804, 1'b0, 1'b1, 3'd4, 2'd0},               // R7 illegal code
    '{4'd7, 32'h808, encFar(6'd43, 26'h2000002), 32'd0, 32'd0, 32'h808, 1'b0, 1'b1, 3'd4, 2'd0},         // R7 high bits set
    '{4'd1, 32'h1234, encCmp(6'd45, 16'h0004), 32'd3, 32'd3, 32'h1238, 1'b0, 1'b0, 3'd0, 2'd0},          // R1 arithmetic op
    '{4'd1, 32'h1234, encCmp(6'd22, 16'h0004), 32'd3, 32'd3, 32'h1238, 1'b0, 1'b0, 3'd0, 2'd0},          // R1 store op
    '{4'd1, 32'hFFFFFFFC, encCmp(6'd45, 16'h0000), 32'd0, 32'd0, 32'h0, 1'b0, 1'b0, 3'd0, 2'd0}          // R1 wrap
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input int req);
    chk(nextPc == 32'd0, req, "nextPc", nextPc, 32'd0);
    chk(!linkWe && !excReq, req, "strobes", {30'd0, linkWe, excReq}, 32'd0);
    chk(linkData == 32'd0 && excCause == 3'd0 && retKind == 2'd0, req, "data",
        {linkData[26:0], excCause, retKind}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL R8 watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    curPc = 32'h40; instr = encFar(6'd62, 26'd8);
    repeat (3) @(negedge clk);
    checkIdle(8); // R8 reset holds outputs idle despite a call on the inputs
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      curPc = VECS[i].pc; instr = VECS[i].ins; regA = VECS[i].a; regB = VECS[i].b;
      @(negedge clk);
      chk(nextPc == VECS[i].expPc, VECS[i].req, "nextPc", nextPc, VECS[i].expPc);
      chk(linkWe == VECS[i].expWe, 5, "linkWe", {31'd0, linkWe}, {31'd0, VECS[i].expWe});
      if (VECS[i].expWe)
        chk(linkData == VECS[i].pc + 32'd4, 5, "linkData", linkData, VECS[i].pc + 32'd4);
      chk(excReq == VECS[i].expExc, 7, "excReq", {31'd0, excReq}, {31'd0, VECS[i].expExc});
      chk(excCause == VECS[i].expCause, 7, "excCause", {29'd0, excCause}, {29'd0, VECS[i].expCause});
      chk(retKind == VECS[i].expRet, 6, "retKind", {30'd0, retKind}, {30'd0, VECS[i].expRet});
    end
    // R8 one-cycle latency: new inputs do not reach the outputs before the edge
    @(negedge clk);
    curPc = 32'h7000; instr = encFar(6'd56, 26'd4);
    #1;
    chk(nextPc == 32'h0, 8, "latency nextPc", nextPc, 32'h0);
    @(negedge clk);
    chk(nextPc == 32'h7010, 8, "latency nextPc", nextPc, 32'h7010);
    // R8 reset in mid stream clears a pending call
    curPc = 32'h500; instr = encReg(6'd54, 5'd2); regA = 32'h900;
    rstN = 1'b0;
    @(negedge clk);
    checkIdle(8);
    rstN = 1'b1;
    @(negedge clk);
    chk(nextPc == 32'h900 && linkWe, 5, "call after reset", nextPc, 32'h900);
    chk(linkData == 32'h504, 5, "linkData", linkData, 32'h504);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule